// File: doc/BRIEF.md
# Wired-to-Message Interrupt Bridge

This block sits between a bank of wired interrupt sources and a receiver that only understands message interrupts, where each message is one event. Every input line has its own tracker with three states: idle, pending (waiting to be sent), and in service (sent and not yet finished). Each entry into the pending state produces exactly one message. The message carries the line's index over a valid/ready handshake. Several pending lines share the single message port in round-robin order.

Software picks a trigger type for each line through a small register port: level-high or rising-edge. It ends service by writing the line's index to a clear register. A level line that is in service also returns to idle by itself once its input is seen low. If a level line is still high when software clears it, the line becomes pending again and sends a fresh message, so that a source still asserting is never lost. A read-only status word shows the state of every line.

Top module: `irq_msg_bridge`

## Requirements
- R1: After reset every line is idle (status code 00), every line is level-high (configuration read returns 0), `msg_valid_o` is low and `cfg_err_o` is low.
- R2: A level-high line whose synchronized input is high leaves idle for pending (status code 01). `msg_valid_o` then rises with `msg_id_o` equal to the line index.
- R3: A line moves from pending to in service (status code 10) only on the cycle its message is accepted (`msg_valid_o` and `msg_ready_i` both high). No further message is sent for that line while it is in service.
- R4: A level-high line in service returns to idle, with no message, once its synchronized input is low.
- R5: A write to address 1 with the line index in `reg_wdata_i[7:0]` forces that line out of its current state. A level-high line whose input is still high goes back to pending and sends one new message; any other line goes to idle.
- R6: In rising-edge mode only a 0-to-1 transition of the synchronized input sets pending. A steady high level does not set pending. An in-service rising-edge line stays in service whatever its input does, until it is cleared.
- R7: A write to address 0 sets the trigger type of the line in `reg_wdata_i[7:0]` from `reg_wdata_i[9:8]` (0 = level-high, 1 = rising-edge). If the type code is 2 or 3, or the index is not below `NUM_LINES`, the write changes nothing and `cfg_err_o` is high for the one cycle after the write.
- R8: When several lines are pending, grants rotate. The line chosen is the first pending index after the last accepted one, wrapping past `NUM_LINES-1` to 0. The first search after reset starts at line 0.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, `msg_id_o` holds its value and the line named stays pending.
- R10: A read of address 2 returns line i's state in bits [2i+1:2i] (00 idle, 01 pending, 10 in service). A read of address 0 returns bit i set when line i is in rising-edge mode. Writes to address 2 have no effect.
- R11: A clear write whose index is not below `NUM_LINES` changes no line's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_LINES | Asynchronous wired interrupt inputs |
| msg_valid_o | output | 1 | A message is offered |
| msg_ready_i | input | 1 | Receiver accepts the offered message |
| msg_id_o | output | ID_W | Line index carried by the message |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 config, 1 clear, 2 status) |
| reg_wdata_i | input | 10 | Write data: [7:0] line index, [9:8] trigger type |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| cfg_err_o | output | 1 | One-cycle pulse after a rejected configuration write |

## Verification
The bench builds the bridge with `NUM_LINES` = 6. Because this is not a power of two, the round-robin search has to wrap at an index that is not a natural bit boundary. The 3-bit ID field also leaves indices 6 and 7 encodable but out of range. That makes the rejected-configuration path and the ignored clear with a bad index reachable through ordinary register writes. Six lines are enough to have four requests pending at once, across both trigger types, while other lines are held in service.

// File: rtl/irqb_pkg.sv
// Shared types and constants for the wired-to-message interrupt bridge.
// Assumes at most 16 lines so the status view fits one 32-bit word.
package irqb_pkg;

    typedef enum logic [1:0] {
        LS_IDLE = 2'b00,
        LS_PEND = 2'b01,
        LS_SERV = 2'b10
    } line_state_e;

    localparam int          REG_DW   = 32;
    localparam int          WDATA_W  = 10;
    localparam int          IDX_W    = 8;
    localparam logic [1:0]  RA_CFG   = 2'd0;
    localparam logic [1:0]  RA_CLR   = 2'd1;
    localparam logic [1:0]  RA_STAT  = 2'd2;

endpackage

// File: rtl/irqb_sync.sv
// Two-flop synchronizer for a vector of asynchronous interrupt inputs.
// Assumes each bit is independent; no bus coherency across bits.
module irqb_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/irqb_line.sv
// Per-line tracker: idle -> pending -> in service, with exit from service
// on level drop (level mode) or on software clear (both modes).
// Assumes lvl_i is already synchronized to clk.
module irqb_line
    import irqb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lvl_i,
    input  logic        edge_mode_i,
    input  logic        acc_i,
    input  logic        clr_i,
    output line_state_e state_o
);

    line_state_e state_q, state_d;
    logic        prev_q;
    logic        rise;
    logic        trig;

    assign rise = lvl_i & ~prev_q;
    assign trig = edge_mode_i ? rise : lvl_i;

    // Next-state selection; software clear overrides every other transition.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: if (trig)                       state_d = LS_PEND;
            LS_PEND: if (acc_i)                      state_d = LS_SERV;
            LS_SERV: if (!edge_mode_i && !lvl_i)     state_d = LS_IDLE;
            default:                                 state_d = LS_IDLE;
        endcase
        if (clr_i) state_d = trig ? LS_PEND : LS_IDLE;
    end

    // State and previous-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= lvl_i;
        end
    end

    assign state_o = state_q;

    p_serv_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LS_SERV && !(state_q == LS_PEND && acc_i && !clr_i)) |=> state_q != LS_SERV);

    p_lvl_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SERV && !edge_mode_i && !lvl_i && !clr_i) |=> state_q == LS_IDLE);

    p_clear_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> state_q != LS_SERV);

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SERV && edge_mode_i && !clr_i) |=> state_q == LS_SERV);

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_PEND && !acc_i && !clr_i) |=> state_q == LS_PEND);

endmodule

// File: rtl/irqb_rr_arb.sv
// Round-robin picker driving the message port. A grant offered but not
// accepted is held while its line stays pending. Assumes N >= 2.
module irqb_rr_arb #(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req_i,
    input  logic           ready_i,
    output logic           valid_o,
    output logic [IDW-1:0] id_o,
    output logic [N-1:0]   acc_o
);

    logic [IDW-1:0] last_q;
    logic           hold_q;
    logic [IDW-1:0] hold_id_q;
    logic [IDW-1:0] pick;
    logic           found;
    logic           use_hold;

    // Search for the first pending line after the last accepted one.
    always_comb begin
        int cand;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            cand = int'(last_q) + 1 + i;
            if (cand >= N) cand = cand - N;
            if (!found && req_i[cand]) begin
                found = 1'b1;
                pick  = IDW'(cand);
            end
        end
    end

    assign use_hold = hold_q && req_i[hold_id_q];
    assign valid_o  = |req_i;
    assign id_o     = use_hold ? hold_id_q : pick;

    // One-hot acceptance strobe for the line being sent.
    always_comb begin
        acc_o = '0;
        if (valid_o && ready_i) acc_o[id_o] = 1'b1;
    end

    // Rotation pointer and stall-hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= IDW'(N - 1);
            hold_q    <= 1'b0;
            hold_id_q <= '0;
        end else begin
            hold_q    <= valid_o && !ready_i;
            hold_id_q <= id_o;
            if (valid_o && ready_i) last_q <= id_o;
        end
    end

    p_id_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (!req_i[$past(id_o)] || id_o == $past(id_o)));

    p_grant_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_o));

endmodule

// File: rtl/irqb_regs.sv
// Register port: per-line trigger type, indexed clear strobe, status view.
// Assumes NUM_LINES <= 16 so 2*NUM_LINES status bits fit the read word.
module irqb_regs
    import irqb_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [1:0]         addr_i,
    input  logic [WDATA_W-1:0] wdata_i,
    input  logic [2*N-1:0]     state_flat_i,
    output logic [REG_DW-1:0]  rdata_o,
    output logic [N-1:0]       edge_mode_o,
    output logic [N-1:0]       clr_o,
    output logic               cfg_err_o
);

    logic [N-1:0]     edge_q;
    logic             err_q;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic             type_bad;
    logic             cfg_wr;
    logic             cfg_ok;

    assign idx      = wdata_i[IDX_W-1:0];
    assign idx_ok   = int'(idx) < N;
    assign type_bad = wdata_i[9];
    assign cfg_wr   = we_i && addr_i == RA_CFG;
    assign cfg_ok   = cfg_wr && idx_ok && !type_bad;

    // Trigger-type storage and rejected-write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= cfg_wr && !(idx_ok && !type_bad);
            if (cfg_ok) edge_q[idx[IDW-1:0]] <= wdata_i[8];
        end
    end

    // Clear strobe for the addressed line, dropped when out of range.
    always_comb begin
        clr_o = '0;
        if (we_i && addr_i == RA_CLR && idx_ok) clr_o[idx[IDW-1:0]] = 1'b1;
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            RA_CFG:  rdata_o[N-1:0]   = edge_q;
            RA_STAT: rdata_o[2*N-1:0] = state_flat_i;
            default: rdata_o          = '0;
        endcase
    end

    assign edge_mode_o = edge_q;
    assign cfg_err_o   = err_q;

    p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(we_i && addr_i == RA_CFG));

    p_cfg_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && type_bad) |=> $stable(edge_q));

endmodule

// File: rtl/irq_msg_bridge.sv
// Top of the wired-to-message interrupt bridge: synchronizes inputs, runs
// one tracker per line, arbitrates pending lines onto a valid/ready message
// port and exposes a small register port. Assumes 2 <= NUM_LINES <= 16.
module irq_msg_bridge
    import irqb_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_i,
    output logic                 msg_valid_o,
    input  logic                 msg_ready_i,
    output logic [ID_W-1:0]      msg_id_o,
    input  logic                 reg_we_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [WDATA_W-1:0]   reg_wdata_i,
    output logic [REG_DW-1:0]    reg_rdata_o,
    output logic                 cfg_err_o
);

    logic [NUM_LINES-1:0]   lvl;
    logic [NUM_LINES-1:0]   edge_mode;
    logic [NUM_LINES-1:0]   clr;
    logic [NUM_LINES-1:0]   acc;
    logic [NUM_LINES-1:0]   pend;
    logic [2*NUM_LINES-1:0] state_flat;

    irqb_sync #(.W(NUM_LINES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_i),
        .q_o   (lvl)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_e st;
        irqb_line line_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .lvl_i       (lvl[g]),
            .edge_mode_i (edge_mode[g]),
            .acc_i       (acc[g]),
            .clr_i       (clr[g]),
            .state_o     (st)
        );
        assign pend[g]               = (st == LS_PEND);
        assign state_flat[2*g +: 2]  = st;
    end

    irqb_rr_arb #(.N(NUM_LINES), .IDW(ID_W)) arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pend),
        .ready_i (msg_ready_i),
        .valid_o (msg_valid_o),
        .id_o    (msg_id_o),
        .acc_o   (acc)
    );

    irqb_regs #(.N(NUM_LINES), .IDW(ID_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (reg_we_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .state_flat_i (state_flat),
        .rdata_o      (reg_rdata_o),
        .edge_mode_o  (edge_mode),
        .clr_o        (clr),
        .cfg_err_o    (cfg_err_o)
    );

    p_valid_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i && !reg_we_i) |=> msg_valid_o);

endmodule

// File: tb/irq_msg_bridge_tb_top.sv
// Directed bench for the interrupt bridge, one task per scenario.
module irq_msg_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 6;
    localparam int IDW = $clog2(NL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   irq = '0;
    logic            msg_valid;
    logic            msg_ready = 1'b0;
    logic [IDW-1:0]  msg_id;
    logic            reg_we = 1'b0;
    logic [1:0]      reg_addr = 2'd0;
    logic [9:0]      reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            cfg_err;

    int checks = 0;
    int errors = 0;
    int last_acc = NL - 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_msg_bridge #(.NUM_LINES(NL)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .msg_valid_o (msg_valid),
        .msg_ready_i (msg_ready),
        .msg_id_o    (msg_id),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .cfg_err_o   (cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [9:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic line_state(input int ln, output logic [1:0] s);
        logic [31:0] d;
        reg_read(2'd2, d);
        s = d[2*ln +: 2];
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 8 && !msg_valid; i++) tick();
    endtask

    task automatic accept(input string req, input int exp_id);
        chk(req, {31'd0, msg_valid}, 32'd1);
        chk(req, {29'd0, msg_id}, exp_id);
        last_acc = msg_id;
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
    endtask

    function automatic int rr_next(input logic [NL-1:0] m);
        for (int i = 0; i < NL; i++) begin
            int c;
            c = (last_acc + 1 + i) % NL;
            if (m[c]) return c;
        end
        return -1;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        reg_read(2'd2, d); chk("R1 status", d, 32'd0);
        reg_read(2'd0, d); chk("R1 cfg", d, 32'd0);
        chk("R1 valid", {31'd0, msg_valid}, 32'd0);
        chk("R1 err", {31'd0, cfg_err}, 32'd0);
    endtask

    task automatic t_level();
        logic [1:0] s;
        irq[2] = 1'b1;
        wait_valid();
        line_state(2, s); chk("R2 pending", s, 2'b01);
        chk("R2 id", {29'd0, msg_id}, 32'd2);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 id held", {29'd0, msg_id}, 32'd2);
            line_state(2, s); chk("R9 still pending", s, 2'b01);
        end
        accept("R2 accept", 2);
        line_state(2, s); chk("R3 in service", s, 2'b10);
        tick(5);
        chk("R3 no repeat", {31'd0, msg_valid}, 32'd0);
        irq[2] = 1'b0;
        tick(4);
        line_state(2, s); chk("R4 idle after drop", s, 2'b00);
        chk("R4 no msg", {31'd0, msg_valid}, 32'd0);
    endtask

    task automatic t_clear_high();
        logic [1:0] s;
        irq[1] = 1'b1;
        wait_valid();
        accept("R5 first", 1);
        reg_write(2'd1, 10'd1);
        line_state(1, s); chk("R5 re-pend", s, 2'b01);
        chk("R5 new msg", {31'd0, msg_valid}, 32'd1);
        accept("R5 second", 1);
        irq[1] = 1'b0;
        tick(4);
        line_state(1, s); chk("R5 idle", s, 2'b00);
    endtask

    task automatic t_edge();
        logic [1:0] s;
        logic [31:0] d;
        reg_write(2'd0, 10'h104);
        reg_read(2'd0, d); chk("R10 cfg bit", d, 32'h10);
        irq[4] = 1'b1;
        wait_valid();
        accept("R6 edge msg", 4);
        irq[4] = 1'b0;
        tick(5);
        line_state(4, s); chk("R6 hold low", s, 2'b10);
        irq[4] = 1'b1;
        tick(5);
        line_state(4, s); chk("R6 hold rerise", s, 2'b10);
        chk("R6 no msg", {31'd0, msg_valid}, 32'd0);
        reg_write(2'd1, 10'd4);
        line_state(4, s); chk("R5 edge clear idle", s, 2'b00);
        tick(4);
        line_state(4, s); chk("R6 high level no pend", s, 2'b00);
        irq[4] = 1'b0;
        tick(4);
        irq[4] = 1'b1;
        wait_valid();
        accept("R6 second edge", 4);
        reg_write(2'd1, 10'd4);
        irq[4] = 1'b0;
        tick(4);
    endtask

    task automatic t_bad_cfg();
        logic [1:0] s;
        logic [31:0] d;
        reg_write(2'd0, 10'h200);
        chk("R7 err pulse", {31'd0, cfg_err}, 32'd1);
        tick();
        chk("R7 err one cycle", {31'd0, cfg_err}, 32'd0);
        reg_read(2'd0, d); chk("R7 type ignored", d, 32'h10);
        reg_write(2'd0, 10'h107);
        chk("R7 idx err", {31'd0, cfg_err}, 32'd1);
        reg_read(2'd0, d); chk("R7 idx ignored", d, 32'h10);
        reg_write(2'd2, 10'h3ff);
        reg_read(2'd2, d); chk("R10 status write ignored", d, 32'd0);
        irq[0] = 1'b1;
        wait_valid();
        accept("R11 setup", 0);
        reg_write(2'd1, 10'd6);
        line_state(0, s); chk("R11 bad clear ignored", s, 2'b10);
        irq[0] = 1'b0;
        tick(4);
    endtask

    task automatic t_rr();
        logic [NL-1:0] m;
        int e;
        reg_write(2'd0, 10'h004);
        m = 6'b100101;
        irq = m;
        wait_valid();
        tick(2);
        e = rr_next(m);
        chk("R9 id held multi", {29'd0, msg_id}, e);
        for (int k = 0; k < 3; k++) begin
            e = rr_next(m);
            accept("R8 round1", e);
            m[e] = 1'b0;
        end
        irq = '0;
        tick(4);
        m = 6'b111010;
        irq = m;
        wait_valid();
        for (int k = 0; k < 4; k++) begin
            e = rr_next(m);
            accept("R8 round2", e);
            m[e] = 1'b0;
        end
        chk("R8 drained", {31'd0, msg_valid}, 32'd0);
        irq = '0;
        tick(4);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_level();
        t_clear_high();
        t_edge();
        t_bad_cfg();
        t_rr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule